// File: doc/BRIEF.md
# USB Single-Ended Transceiver Control Logic

This block is the digital control side of a full-speed/low-speed USB transceiver. On the transmit side it takes two inputs from a serial interface engine. One is a data bit and the other is a force-SE0 request. It turns them into D+/D- drive values and a shared drive enable. On the receive side it takes sampled D+/D- levels and produces three outputs: a differential data bit, which keeps its previous value through single-ended-zero periods, and the two raw single-ended line levels.

Around that datapath sits a mode decoder. It takes two supply-presence flags, a high-impedance request and a suspend request. It chooses between normal operation, suspend, supply sharing (I/O rail only), high impedance and disabled (no I/O rail). Each mode overrides the bus drivers, the receive outputs and the pull-up switch controls. The analog parts of a transceiver are not modelled: slew control, receiver thresholds, resistor switching and supply sensing. The bus appears as separate input, output and output-enable signals.

Top module: `usbse_xcvr`

## Requirements
- R1: While driving with `tx_se0` low, `tx_data`=0 gives `{dp_out,dm_out}`=01 and `tx_data`=1 gives 10.
- R2: While driving with `tx_se0` high, `{dp_out,dm_out}`=00 whatever `tx_data` is.
- R3: `bus_oe` is 1 only when `oe_n`=0, `force_rx`=0 and the mode is normal or suspend (both supply flags 1, `hiz_req`=0). In every other case `bus_oe`=0 and `dp_out`=`dm_out`=0. `force_rx` overrides `oe_n`.
- R4: In normal mode (`susp_req`=0), bus 10 gives `rx_diff`=1 and bus 01 gives `rx_diff`=0, with no clock latency. `rx_dp` and `rx_dm` follow `dp_in` and `dm_in`.
- R5: In normal mode, on bus 00 (SE0) or 11, `rx_diff` shows the hold register. The hold register takes the value of `dp_in` on every rising clock edge in normal mode where the bus is 10 or 01. Its reset value is 1.
- R6: In suspend (normal supplies, `hiz_req`=0, `susp_req`=1), `rx_diff`=0 while `rx_dp`/`rx_dm` still follow the bus and transmit still works.
- R7: Sharing mode (`io_sup_ok`=1, `core_sup_ok`=0, `hiz_req`=0) sets `bus_oe`=0, `rx_dp`=`rx_dm`=1, `rx_diff`=0, `rx_oe`=1, `pu_en`=0 and `low_pwr`=1.
- R8: With `io_sup_ok`=1 and `hiz_req`=1, the block sets `bus_oe`=0, `rx_oe`=0 (all three receive outputs read 0) and `pu_en`=0. `low_pwr` is 0.
- R9: With `io_sup_ok`=0, the block sets `bus_oe`=0, `rx_oe`=0, `pu_en`=0 and `low_pwr`=1, whatever the other inputs are.
- R10: `pu_en[i]` equals `pu_req[i]` in normal and suspend modes and is 0 in every other mode.
- R11: The hold register does not change while the mode is not normal. After an exit from suspend straight into SE0, `rx_diff` shows the value that was held before the suspend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_sup_ok | input | 1 | I/O rail present flag |
| core_sup_ok | input | 1 | Core 3.3 V rail present flag |
| hiz_req | input | 1 | High-impedance request |
| susp_req | input | 1 | Suspend request |
| oe_n | input | 1 | Drive enable, active low |
| force_rx | input | 1 | Forced receive from extended control |
| tx_data | input | 1 | Transmit data bit |
| tx_se0 | input | 1 | Force SE0 on the bus |
| pu_req | input | NUM_PU | Pull-up switch requests |
| dp_in | input | 1 | Sampled D+ level |
| dm_in | input | 1 | Sampled D- level |
| dp_out | output | 1 | D+ drive value |
| dm_out | output | 1 | D- drive value |
| bus_oe | output | 1 | D+/D- drive enable |
| rx_diff | output | 1 | Differential receive data |
| rx_dp | output | 1 | Single-ended D+ output |
| rx_dm | output | 1 | Single-ended D- output |
| rx_oe | output | 1 | Enable for the three receive outputs |
| pu_en | output | NUM_PU | Pull-up switch closes |
| low_pwr | output | 1 | Low-power indication |

## Verification
Every output except `rx_diff` during SE0/11 is combinational, so each output is due in the same cycle as its inputs. The bench drives inputs on the falling edge and compares one nanosecond later, before the next rising edge. The hold register is the only state. The bench's own copy of it is advanced just after each rising edge, from the inputs that were stable across that edge. An SE0 check therefore expects the value of the last J or K seen in normal mode on an earlier edge. Directed sequences cover the reset value, suspend exit into SE0, and each supply override. A fixed-seed random phase covers the mixed cases.

// File: rtl/usbse_pkg.sv
package usbse_pkg;

    typedef enum logic [2:0] {
        MD_OFF   = 3'd0,
        MD_HIZ   = 3'd1,
        MD_SHARE = 3'd2,
        MD_SUSP  = 3'd3,
        MD_RUN   = 3'd4
    } xcvr_mode_e;

    typedef struct packed {
        logic dp;
        logic dm;
    } line_pair_t;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_K   = 2'b01,
        LS_J   = 2'b10,
        LS_SE1 = 2'b11
    } line_state_e;

    typedef struct packed {
        logic diff;
        logic dp;
        logic dm;
        logic oe;
    } rx_bundle_t;

    function automatic line_state_e classify(line_pair_t p);
        return line_state_e'({p.dp, p.dm});
    endfunction

    function automatic line_pair_t tx_encode(logic data, logic se0);
        line_pair_t r;
        r.dp = se0 ? 1'b0 : data;
        r.dm = se0 ? 1'b0 : ~data;
        return r;
    endfunction

    function automatic logic may_drive(xcvr_mode_e m);
        return (m == MD_RUN) || (m == MD_SUSP);
    endfunction

endpackage

// File: rtl/usbse_mode_dec.sv
module usbse_mode_dec
    import usbse_pkg::*;
(
    input  logic       io_ok,
    input  logic       core_ok,
    input  logic       hiz,
    input  logic       susp,
    output xcvr_mode_e mode,
    output logic       low_pwr,
    output logic       rcv_on
);
    always_comb begin
        if (!io_ok)
            mode = MD_OFF;
        else if (hiz)
            mode = MD_HIZ;
        else if (!core_ok)
            mode = MD_SHARE;
        else if (susp)
            mode = MD_SUSP;
        else
            mode = MD_RUN;
    end

    assign low_pwr = (mode == MD_OFF) || (mode == MD_SHARE);
    assign rcv_on  = (mode == MD_RUN);
endmodule

// File: rtl/usbse_tx.sv
module usbse_tx
    import usbse_pkg::*;
(
    input  xcvr_mode_e mode,
    input  logic       oe_n,
    input  logic       force_rx,
    input  logic       data,
    input  logic       se0,
    output line_pair_t drv,
    output logic       drv_en
);
    line_pair_t enc;

    always_comb begin
        enc    = tx_encode(data, se0);
        drv_en = may_drive(mode) && !oe_n && !force_rx;
        drv    = drv_en ? enc : '0;
    end
endmodule

// File: rtl/usbse_rx.sv
module usbse_rx
    import usbse_pkg::*;
#(
    parameter logic HOLD_INIT = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  xcvr_mode_e mode,
    input  logic       rcv_on,
    input  line_pair_t bus,
    output rx_bundle_t rx
);
    line_state_e st;
    logic        hold_q;
    logic        is_diff;

    assign st      = classify(bus);
    assign is_diff = (st == LS_J) || (st == LS_K);

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= HOLD_INIT;
        else if (rcv_on && is_diff)
            hold_q <= (st == LS_J);
    end

    always_comb begin
        rx = '0;
        unique case (mode)
            MD_OFF, MD_HIZ: rx = '0;
            MD_SHARE: begin
                rx.diff = 1'b0;
                rx.dp   = 1'b1;
                rx.dm   = 1'b1;
                rx.oe   = 1'b1;
            end
            MD_SUSP: begin
                rx.diff = 1'b0;
                rx.dp   = bus.dp;
                rx.dm   = bus.dm;
                rx.oe   = 1'b1;
            end
            default: begin
                rx.diff = is_diff ? (st == LS_J) : hold_q;
                rx.dp   = bus.dp;
                rx.dm   = bus.dm;
                rx.oe   = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/usbse_xcvr.sv
module usbse_xcvr
    import usbse_pkg::*;
#(
    parameter int   NUM_PU    = 2,
    parameter logic HOLD_INIT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_sup_ok,
    input  logic              core_sup_ok,
    input  logic              hiz_req,
    input  logic              susp_req,
    input  logic              oe_n,
    input  logic              force_rx,
    input  logic              tx_data,
    input  logic              tx_se0,
    input  logic [NUM_PU-1:0] pu_req,
    input  logic              dp_in,
    input  logic              dm_in,
    output logic              dp_out,
    output logic              dm_out,
    output logic              bus_oe,
    output logic              rx_diff,
    output logic              rx_dp,
    output logic              rx_dm,
    output logic              rx_oe,
    output logic [NUM_PU-1:0] pu_en,
    output logic              low_pwr
);
    localparam int PU_LAST = NUM_PU - 1;

    xcvr_mode_e mode;
    logic       rcv_on;
    line_pair_t drv;
    line_pair_t bus_s;
    rx_bundle_t rx;
    logic       pu_allow;

    usbse_mode_dec u_mode (
        .io_ok   (io_sup_ok),
        .core_ok (core_sup_ok),
        .hiz     (hiz_req),
        .susp    (susp_req),
        .mode    (mode),
        .low_pwr (low_pwr),
        .rcv_on  (rcv_on)
    );

    usbse_tx u_tx (
        .mode     (mode),
        .oe_n     (oe_n),
        .force_rx (force_rx),
        .data     (tx_data),
        .se0      (tx_se0),
        .drv      (drv),
        .drv_en   (bus_oe)
    );

    assign bus_s.dp = dp_in;
    assign bus_s.dm = dm_in;

    usbse_rx #(.HOLD_INIT(HOLD_INIT)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .rcv_on (rcv_on),
        .bus    (bus_s),
        .rx     (rx)
    );

    assign dp_out  = drv.dp;
    assign dm_out  = drv.dm;
    assign rx_diff = rx.diff;
    assign rx_dp   = rx.dp;
    assign rx_dm   = rx.dm;
    assign rx_oe   = rx.oe;

    assign pu_allow = may_drive(mode);

    for (genvar i = 0; i <= PU_LAST; i++) begin : g_pu
        assign pu_en[i] = pu_req[i] & pu_allow;
    end
endmodule

// File: rtl/usbse_chk.sv
module usbse_chk #(
    parameter int NUM_PU = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              io_sup_ok,
    input logic              core_sup_ok,
    input logic              hiz_req,
    input logic              susp_req,
    input logic              oe_n,
    input logic              force_rx,
    input logic              tx_data,
    input logic              tx_se0,
    input logic              dp_in,
    input logic              dm_in,
    input logic              dp_out,
    input logic              dm_out,
    input logic              bus_oe,
    input logic              rx_diff,
    input logic              rx_dp,
    input logic              rx_dm,
    input logic              rx_oe,
    input logic [NUM_PU-1:0] pu_en,
    input logic              low_pwr
);
    logic run_se0;
    assign run_se0 = io_sup_ok && core_sup_ok && !hiz_req && !susp_req && (dp_in == dm_in);

    AST_TX_MAP: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && !tx_se0) |-> (dp_out == tx_data && dm_out == !tx_data)); // R1
    AST_TX_SE0: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && tx_se0) |-> (!dp_out && !dm_out)); // R2
    AST_NO_DRIVE_FORCED: assert property (@(posedge clk) disable iff (rst)
        (oe_n || force_rx) |-> !bus_oe); // R3
    AST_SE0_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run_se0 && $past(run_se0)) |-> $stable(rx_diff)); // R5
    AST_SUSP_RX: assert property (@(posedge clk) disable iff (rst)
        (io_sup_ok && core_sup_ok && !hiz_req && susp_req) |-> (!rx_diff && rx_dp == dp_in && rx_dm == dm_in)); // R6
    AST_SHARE: assert property (@(posedge clk) disable iff (rst)
        (io_sup_ok && !core_sup_ok && !hiz_req) |-> (!bus_oe && rx_dp && rx_dm && !rx_diff && low_pwr)); // R7
    AST_HIZ_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (io_sup_ok && hiz_req) |-> (!bus_oe && !rx_oe && pu_en == '0)); // R8
    AST_IO_LOST: assert property (@(posedge clk) disable iff (rst)
        !io_sup_ok |-> (low_pwr && !bus_oe && !rx_oe && pu_en == '0)); // R9
endmodule

bind usbse_xcvr usbse_chk #(.NUM_PU(NUM_PU)) u_chk (.*);

// File: tb/tb_usbse_xcvr.sv
`timescale 1ns/1ps
module tb_usbse_xcvr;
    localparam int NPU = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic io_sup_ok = 1, core_sup_ok = 1, hiz_req = 0, susp_req = 0;
    logic oe_n = 1, force_rx = 0, tx_data = 0, tx_se0 = 0;
    logic [NPU-1:0] pu_req = '0;
    logic dp_in = 0, dm_in = 0;
    logic dp_out, dm_out, bus_oe, rx_diff, rx_dp, rx_dm, rx_oe, low_pwr;
    logic [NPU-1:0] pu_en;

    int n_run = 0, n_fail = 0;
    logic m_hold = 1'b1;
    bit done = 0;

    always #4 clk = ~clk;

    usbse_xcvr #(.NUM_PU(NPU)) dut (.*);

    function automatic int mode_of();
        if (!io_sup_ok) return 0;
        if (hiz_req) return 1;
        if (!core_sup_ok) return 2;
        if (susp_req) return 3;
        return 4;
    endfunction

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all(input string force_tag);
        int m;
        logic drv, e_oe, e_dp, e_dm, e_diff, e_rdp, e_rdm, e_roe, e_lp;
        logic [NPU-1:0] e_pu;
        string tb, tr, tp;
        m    = mode_of();
        drv  = (m >= 3) && !oe_n && !force_rx;
        e_oe = drv;
        e_dp = drv && !tx_se0 && tx_data;
        e_dm = drv && !tx_se0 && !tx_data;
        e_roe = (m >= 2);
        e_lp  = (m == 0) || (m == 2);
        e_pu  = (m >= 3) ? pu_req : '0;
        e_rdp = (m == 2) ? 1'b1 : (m >= 3 ? dp_in : 1'b0);
        e_rdm = (m == 2) ? 1'b1 : (m >= 3 ? dm_in : 1'b0);
        e_diff = (m == 4) ? ((dp_in != dm_in) ? dp_in : m_hold) : 1'b0;
        case (m)
            0: begin tb = "R9"; tr = "R9"; tp = "R9"; end
            1: begin tb = "R8"; tr = "R8"; tp = "R8"; end
            2: begin tb = "R7"; tr = "R7"; tp = "R7"; end
            3: begin tb = "R6"; tr = "R6"; tp = "R10"; end
            default: begin tb = "R3"; tr = (dp_in != dm_in) ? "R4" : "R5"; tp = "R10"; end
        endcase
        if (m >= 3 && drv) tb = tx_se0 ? "R2" : "R1";
        if (force_tag != "") begin tr = force_tag; end
        chk(tb, "bus_oe", 8'(bus_oe), 8'(e_oe));
        chk(tb, "dp_out", 8'(dp_out), 8'(e_dp));
        chk(tb, "dm_out", 8'(dm_out), 8'(e_dm));
        chk(tr, "rx_diff", 8'(rx_diff), 8'(e_diff));
        chk(tr, "rx_dp", 8'(rx_dp), 8'(e_rdp));
        chk(tr, "rx_dm", 8'(rx_dm), 8'(e_rdm));
        chk(tr, "rx_oe", 8'(rx_oe), 8'(e_roe));
        chk(tb, "low_pwr", 8'(low_pwr), 8'(e_lp));
        chk(tp, "pu_en", 8'(pu_en), 8'(e_pu));
    endtask

    // one cycle: inputs already set at negedge; check, then advance model at posedge
    task automatic cycle(input string force_tag);
        #1;
        check_all(force_tag);
        @(posedge clk);
        if (rst) m_hold = 1'b1;
        else if (mode_of() == 4 && dp_in != dm_in) m_hold = dp_in;
        @(negedge clk);
    endtask

    task automatic set_bus(input logic p, input logic m);
        dp_in = p; dm_in = m;
    endtask

    initial begin
        void'($urandom(32'h1D5E_0A17));
        @(negedge clk);
        set_bus(0, 0);
        repeat (2) cycle("");
        rst = 0;
        // R5: reset value of hold shown during SE0
        cycle("R5");
        // R4 decode J and K
        set_bus(1, 0); cycle("R4");
        set_bus(0, 1); cycle("R4");
        // R5 SE0 holds K (0), SE1 too
        set_bus(0, 0); cycle("R5");
        set_bus(1, 1); cycle("R5");
        // R1 / R2 transmit
        oe_n = 0; tx_data = 1; cycle("");
        tx_data = 0; cycle("");
        tx_se0 = 1; cycle("");
        tx_data = 1; cycle("");
        // R3 force_rx overrides oe_n
        force_rx = 1; cycle("");
        force_rx = 0; tx_se0 = 0;
        // R11: hold 0 (last K), suspend with J seen, exit into SE0 shows stale 0
        set_bus(0, 1); cycle("R4");
        susp_req = 1; pu_req = 2'b11;
        set_bus(1, 0); repeat (3) cycle("R6");
        susp_req = 0; set_bus(0, 0); cycle("R11");
        // R7 sharing, R8 hiz, R9 io lost
        core_sup_ok = 0; cycle("");
        core_sup_ok = 1; hiz_req = 1; cycle("");
        io_sup_ok = 0; cycle("");
        hiz_req = 0; cycle("");
        io_sup_ok = 1; set_bus(0, 0); cycle("R11");
        // random phase
        for (int i = 0; i < 3000; i++) begin
            io_sup_ok   = ($urandom % 20) != 0;
            core_sup_ok = ($urandom % 10) != 0;
            hiz_req     = ($urandom % 10) == 0;
            susp_req    = ($urandom % 5) == 0;
            oe_n        = $urandom % 2;
            force_rx    = ($urandom % 10) == 0;
            tx_data     = $urandom % 2;
            tx_se0      = ($urandom % 5) == 0;
            pu_req      = NPU'($urandom);
            if (($urandom % 3) == 0) set_bus(0, 0);
            else set_bus($urandom % 2, $urandom % 2);
            cycle("");
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule